// File: doc/BRIEF.md
# First-Fire Classification Scorer

The scorer watches the spike lines of a spiking network's output layer during one recognition trial and grades the answer the network gives. A trial opens on a start strobe and closes on an end strobe. While it is open the block builds a record of which outputs fired. In the default competitive mode, the first cycle that carries any spike fixes the record, and every later spike in that trial is ignored. In the record-all mode, every output that fires at any time is kept.

When a trial closes, the record is compared with a one-hot target vector. The trial is graded as accurate, ambiguous, undetected or misclassified. The grade is then folded into four per-grade trial counters, a running count of fired outputs, and a signed fixed-point score. The score rewards correct answers and charges a small penalty for every output spike. A clear strobe restarts the tallies for a new evaluation run.

Top module: `fire_scorer`

## Requirements
- R1: While rst_ni is low and after it rises, all four grade counters, the fired count and the score read zero, and cat_valid_o is low.
- R2: With the mode latched as competitive (record_all_i = 0), the first sampled cycle with any nonzero spike_i stores every spike of that cycle, several of them if they arrive together. Spikes on later cycles of that trial are ignored.
- R3: With the mode latched as record-all (record_all_i = 1), every output that spikes on any sampled cycle of the trial is stored.
- R4: record_all_i is sampled only on a trial_start_i cycle. Changing it during a trial has no effect on that trial.
- R5: spike_i is sampled only on cycles when a trial is open and neither trial_start_i nor trial_end_i is high. Spikes outside a trial, on its start cycle or on its end cycle are ignored.
- R6: On the cycle after a trial_end_i that closes an open trial, cat_valid_o is high for one cycle and cat_o carries the grade. The codes are: 2'b00 accurate (record equals target), 2'b01 ambiguous (the target output fired along with at least one other), 2'b10 undetected (nothing fired), 2'b11 misclassified (some output fired, but not the target).
- R7: In that same cycle the counter for the reported grade has gone up by one, and fired_cnt_o has gone up by the number of outputs in the record.
- R8: score_o is two's complement in units of 0.02. Each graded trial adds 50 if accurate, 25 if ambiguous, 25 if undetected and 0 if misclassified, and subtracts the number of outputs in the record.
- R9: clear_i zeroes all counters and the score on the next cycle. This takes priority over a trial ending in the same cycle, whose grade is still reported on cat_o but is not tallied.
- R10: trial_end_i with no open trial does nothing. trial_start_i while a trial is open discards its record and opens a fresh trial. A start and an end in the same cycle grade the open trial and then open a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero the tallies and the score |
| trial_start_i | input | 1 | Open a trial and latch the mode |
| trial_end_i | input | 1 | Close and grade the open trial |
| record_all_i | input | 1 | 1: record every firing, 0: competitive first firing |
| spike_i | input | N_OUT | Output-layer spike lines |
| desired_i | input | N_OUT | One-hot target, sampled with trial_end_i |
| cat_o | output | 2 | Grade of the last closed trial |
| cat_valid_o | output | 1 | One-cycle pulse, cat_o is fresh |
| accurate_cnt_o | output | CNT_W | Accurate trials |
| ambiguous_cnt_o | output | CNT_W | Ambiguous trials |
| undetected_cnt_o | output | CNT_W | Undetected trials |
| miscls_cnt_o | output | CNT_W | Misclassified trials |
| fired_cnt_o | output | CNT_W | Outputs fired across graded trials |
| score_o | output | SCORE_W | Signed score, unit 0.02 |

## Verification
The bench builds the block with four outputs, so every combination of simultaneous first firings and every target position can be reached in a short run. It uses 6-bit counters, so the fired count wraps several times during the random phase, and a 20-bit score, which misclassified trials can push downward without overflow. Directed trials cover each grade, the latched mode, ignored spikes on the strobe cycles, back-to-back start and end, and a clear that collides with an end. A long random phase then mixes all strobes against a behavioural model.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    CAT_ACCURATE   = 2'b00,
    CAT_AMBIGUOUS  = 2'b01,
    CAT_UNDETECTED = 2'b10,
    CAT_MISCLASS   = 2'b11
  } fs_cat_e;

  localparam int unsigned NUM_CATS = 4;
  // score unit is 0.02: full credit 1.0, half credit 0.5
  localparam int unsigned PTS_FULL = 50;
  localparam int unsigned PTS_HALF = 25;
endpackage

// File: rtl/fs_capture.sv
module fs_capture #(
  parameter int unsigned N_OUT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             mode_i,
  input  logic [N_OUT-1:0] spike_i,
  output logic             open_o,
  output logic [N_OUT-1:0] vec_o
);
  logic             open_q, open_d;
  logic             all_q, all_d;
  logic [N_OUT-1:0] vec_q, vec_d;
  logic             sample;

  always_comb begin
    sample = open_q && !start_i && !end_i;
    vec_d  = vec_q;
    if (start_i) begin
      vec_d = '0;
    end else if (sample) begin
      if (all_q)              vec_d = vec_q | spike_i;
      else if (vec_q == '0)   vec_d = spike_i;  // competitive: first firing cycle only
    end
    open_d = start_i ? 1'b1 : (end_i ? 1'b0 : open_q);
    all_d  = start_i ? mode_i : all_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      all_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      open_q <= open_d;
      all_q  <= all_d;
      vec_q  <= vec_d;
    end
  end

  assign open_o = open_q;
  assign vec_o  = vec_q;

  a_r2_competitive_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !all_q && (vec_q != '0) && !start_i) |=> $stable(vec_q));

  a_r3_record_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i) |=> ((vec_q & $past(vec_q)) == $past(vec_q)));

  a_r4_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i) |=> $stable(all_q));

  a_r5_closed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !start_i) |=> $stable(vec_q));
endmodule

// File: rtl/fs_classify.sv
module fs_classify
  import fs_pkg::*;
#(
  parameter int unsigned N_OUT  = 10,
  parameter int unsigned FIRE_W = 4
) (
  input  logic [N_OUT-1:0]  vec_i,
  input  logic [N_OUT-1:0]  desired_i,
  output fs_cat_e           cat_o,
  output logic [FIRE_W-1:0] fired_o
);
  logic exact, hit, any;

  always_comb begin
    exact = (vec_i == desired_i);
    hit   = |(vec_i & desired_i);
    any   = |vec_i;
    if (exact)     cat_o = CAT_ACCURATE;
    else if (hit)  cat_o = CAT_AMBIGUOUS;
    else if (!any) cat_o = CAT_UNDETECTED;
    else           cat_o = CAT_MISCLASS;
  end

  always_comb begin
    fired_o = '0;
    for (int i = 0; i < int'(N_OUT); i++) fired_o = fired_o + FIRE_W'(vec_i[i]);
  end
endmodule

// File: rtl/fs_accum.sv
module fs_accum
  import fs_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SCORE_W = 24,
  parameter int unsigned FIRE_W  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              upd_i,
  input  fs_cat_e                           cat_i,
  input  logic [FIRE_W-1:0]                 fired_i,
  output logic [NUM_CATS-1:0][CNT_W-1:0]    cat_cnt_o,
  output logic [CNT_W-1:0]                  fired_cnt_o,
  output logic signed [SCORE_W-1:0]         score_o
);
  logic                      tally;
  logic signed [SCORE_W-1:0] pts;
  logic signed [SCORE_W-1:0] score_q;
  logic [CNT_W-1:0]          fired_q;

  assign tally = upd_i && !clear_i;

  always_comb begin
    unique case (cat_i)
      CAT_ACCURATE:                  pts = SCORE_W'(PTS_FULL);
      CAT_AMBIGUOUS, CAT_UNDETECTED: pts = SCORE_W'(PTS_HALF);
      default:                       pts = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CATS; g++) begin : g_cat_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cnt_q <= '0;
      else if (clear_i)                              cnt_q <= '0;
      else if (tally && (cat_i == fs_cat_e'(g)))     cnt_q <= cnt_q + 1'b1;
    end
    assign cat_cnt_o[g] = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q <= '0;
      fired_q <= '0;
    end else if (clear_i) begin
      score_q <= '0;
      fired_q <= '0;
    end else if (tally) begin
      score_q <= score_q + pts - $signed(SCORE_W'(fired_i));
      fired_q <= fired_q + CNT_W'(fired_i);
    end
  end

  assign score_o     = score_q;
  assign fired_cnt_o = fired_q;

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (score_q == '0) && (fired_q == '0));

  a_r7_hold_without_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clear_i) |=> $stable(score_q) && $stable(fired_q));
endmodule

// File: rtl/fire_scorer.sv
module fire_scorer
  import fs_pkg::*;
#(
  parameter int unsigned N_OUT   = 10,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SCORE_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      trial_start_i,
  input  logic                      trial_end_i,
  input  logic                      record_all_i,
  input  logic [N_OUT-1:0]          spike_i,
  input  logic [N_OUT-1:0]          desired_i,
  output logic [1:0]                cat_o,
  output logic                      cat_valid_o,
  output logic [CNT_W-1:0]          accurate_cnt_o,
  output logic [CNT_W-1:0]          ambiguous_cnt_o,
  output logic [CNT_W-1:0]          undetected_cnt_o,
  output logic [CNT_W-1:0]          miscls_cnt_o,
  output logic [CNT_W-1:0]          fired_cnt_o,
  output logic signed [SCORE_W-1:0] score_o
);
  localparam int unsigned FIRE_W = $clog2(N_OUT + 1);

  logic                           open;
  logic [N_OUT-1:0]               vec;
  fs_cat_e                        cls_cat;
  logic [FIRE_W-1:0]              fired;
  logic                           upd;
  logic [NUM_CATS-1:0][CNT_W-1:0] cat_cnt;
  fs_cat_e                        cat_q;
  logic                           valid_q;

  fs_capture #(.N_OUT(N_OUT)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (trial_start_i),
    .end_i   (trial_end_i),
    .mode_i  (record_all_i),
    .spike_i (spike_i),
    .open_o  (open),
    .vec_o   (vec)
  );

  fs_classify #(.N_OUT(N_OUT), .FIRE_W(FIRE_W)) i_classify (
    .vec_i     (vec),
    .desired_i (desired_i),
    .cat_o     (cls_cat),
    .fired_o   (fired)
  );

  assign upd = trial_end_i && open;

  fs_accum #(.CNT_W(CNT_W), .SCORE_W(SCORE_W), .FIRE_W(FIRE_W)) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .upd_i       (upd),
    .cat_i       (cls_cat),
    .fired_i     (fired),
    .cat_cnt_o   (cat_cnt),
    .fired_cnt_o (fired_cnt_o),
    .score_o     (score_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cat_q   <= CAT_ACCURATE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd;
      if (upd) cat_q <= cls_cat;
    end
  end

  assign cat_o            = cat_q;
  assign cat_valid_o      = valid_q;
  assign accurate_cnt_o   = cat_cnt[CAT_ACCURATE];
  assign ambiguous_cnt_o  = cat_cnt[CAT_AMBIGUOUS];
  assign undetected_cnt_o = cat_cnt[CAT_UNDETECTED];
  assign miscls_cnt_o     = cat_cnt[CAT_MISCLASS];

  a_r10_idle_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trial_end_i && !open) |=> !cat_valid_o);

  a_r6_valid_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cat_valid_o |-> $past(trial_end_i));

  a_r6_ambiguous_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && (cls_cat == CAT_AMBIGUOUS)) |-> (fired >= FIRE_W'(2)));
endmodule

// File: tb/test_fire_scorer.sv
module test_fire_scorer;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          clr = 0, t_start = 0, t_end = 0, mode = 0;
  logic [N-1:0]  spk = '0, des = '0;
  logic [1:0]    cat;
  logic          cat_valid;
  logic [CW-1:0] acc_c, amb_c, und_c, mis_c, fir_c;
  logic signed [SW-1:0] score;

  fire_scorer #(.N_OUT(N), .CNT_W(CW), .SCORE_W(SW)) i_fire_scorer (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .trial_start_i(t_start),
    .trial_end_i(t_end), .record_all_i(mode), .spike_i(spk), .desired_i(des),
    .cat_o(cat), .cat_valid_o(cat_valid), .accurate_cnt_o(acc_c),
    .ambiguous_cnt_o(amb_c), .undetected_cnt_o(und_c), .miscls_cnt_o(mis_c),
    .fired_cnt_o(fir_c), .score_o(score)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit           m_open, m_all, m_valid;
  logic [N-1:0] m_vec;
  int           m_cnt[4];
  int           m_fired, m_score, m_cat;

  function automatic int grade(logic [N-1:0] v, logic [N-1:0] d);
    if (v == d) return 0;
    if ((v & d) != 0) return 1;
    if (v == 0) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_all = 0; m_valid = 0; m_vec = '0; m_cat = 0;
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_fired = 0; m_score = 0;
    end else begin
      m_valid = 0;
      if (t_end && m_open) begin
        m_cat = grade(m_vec, des);
        m_valid = 1;
        if (!clr) begin
          int f;
          f = $countones(m_vec);
          m_cnt[m_cat]++;
          m_fired += f;
          m_score += ((m_cat == 0) ? 50 : (m_cat == 3) ? 0 : 25) - f;
        end
      end
      if (clr) begin
        foreach (m_cnt[k]) m_cnt[k] = 0;
        m_fired = 0; m_score = 0;
      end
      if (t_start) begin
        m_open = 1; m_all = mode; m_vec = '0;
      end else if (t_end) begin
        m_open = 0;
      end else if (m_open) begin
        if (m_all) m_vec = m_vec | spk;
        else if (m_vec == 0) m_vec = spk;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 valid pulse", int'(cat_valid), int'(m_valid));
      if (m_valid) chk("R6 category", int'(cat), m_cat);
      chk("R7 accurate count", int'(acc_c), m_cnt[0] & 63);
      chk("R7 ambiguous count", int'(amb_c), m_cnt[1] & 63);
      chk("R7 undetected count", int'(und_c), m_cnt[2] & 63);
      chk("R7 misclassified count", int'(mis_c), m_cnt[3] & 63);
      chk("R7 fired count", int'(fir_c), m_fired & 63);
      chk("R8 score", int'(score), m_score);
    end
  end

  task automatic open_trial(logic m);
    t_start = 1; mode = m;
    @(negedge clk);
    t_start = 0;
  endtask

  task automatic fire(logic [N-1:0] v);
    spk = v;
    @(negedge clk);
    spk = '0;
  endtask

  task automatic close_trial(logic [N-1:0] d, int exp_cat, string req);
    t_end = 1; des = d;
    @(negedge clk);
    t_end = 0;
    chk(req, int'(cat_valid), 1);
    chk(req, int'(cat), exp_cat);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 score in reset", int'(score), 0);
    chk("R1 fired in reset", int'(fir_c), 0);
    chk("R1 valid in reset", int'(cat_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 accurate after reset", int'(acc_c), 0);

    open_trial(0); fire(4'b0010); fire(4'b0101);
    close_trial(4'b0010, 0, "R2 first firing wins");
    chk("R8 score after accurate", int'(score), 49);

    open_trial(0); fire(4'b0110); fire(4'b1000);
    close_trial(4'b0010, 1, "R2 simultaneous firing ambiguous");
    chk("R8 score after ambiguous", int'(score), 72);
    chk("R7 fired total", int'(fir_c), 3);

    open_trial(1); fire(4'b0001); fire(4'b1000);
    close_trial(4'b0010, 3, "R3 record all misclassified");
    chk("R8 score after misclass", int'(score), 70);

    open_trial(0); @(negedge clk);
    close_trial(4'b0010, 2, "R6 undetected");
    chk("R8 score after undetected", int'(score), 95);

    t_start = 1; mode = 0; @(negedge clk); t_start = 0; mode = 1;
    fire(4'b0100); fire(4'b0010); mode = 0;
    close_trial(4'b0100, 0, "R4 mode latched at start");

    fire(4'b0001);
    t_start = 1; spk = 4'b0001; @(negedge clk); t_start = 0; spk = '0;
    @(negedge clk);
    t_end = 1; des = 4'b0001; spk = 4'b0001; @(negedge clk); t_end = 0; spk = '0;
    chk("R5 strobe-cycle spikes ignored", int'(cat), 2);

    t_end = 1; @(negedge clk); t_end = 0;
    chk("R10 end without trial", int'(cat_valid), 0);

    open_trial(0); fire(4'b1000);
    t_end = 1; t_start = 1; des = 4'b1000; @(negedge clk); t_end = 0; t_start = 0;
    chk("R10 end with start valid", int'(cat_valid), 1);
    chk("R10 end with start grade", int'(cat), 0);
    fire(4'b0100);
    close_trial(4'b0100, 0, "R10 reopened trial");

    open_trial(0); fire(4'b0001); open_trial(0); fire(4'b0010);
    close_trial(4'b0010, 0, "R10 restart discards record");

    open_trial(0); fire(4'b0001);
    t_end = 1; clr = 1; des = 4'b0001; @(negedge clk); t_end = 0; clr = 0;
    chk("R9 graded despite clear", int'(cat_valid), 1);
    chk("R9 score cleared", int'(score), 0);
    chk("R9 accurate cleared", int'(acc_c), 0);
    chk("R9 fired cleared", int'(fir_c), 0);

    for (int n = 0; n < 4000; n++) begin
      t_start = ($urandom_range(7) == 0);
      t_end   = ($urandom_range(5) == 0);
      clr     = ($urandom_range(199) == 0);
      mode    = $urandom_range(1);
      spk     = ($urandom_range(2) == 0) ? N'($urandom_range(15)) : '0;
      des     = N'(1) << $urandom_range(N - 1);
      @(negedge clk);
    end
    t_start = 0; t_end = 0; clr = 0; spk = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule